// File: doc/BRIEF.md
# IOMMU Context Register Bank

This block is the software-visible register file of a small I/O memory-management unit. It holds a fixed number of translation contexts, eight by default. Each context has a control word, a translation-config word, a two-word table base, a fault status word and a two-word fault address. A 32-bit register bus reaches them at byte addresses. Context `n` occupies a 64-byte window starting at `BASE_ADDR + n*0x40`. Reads return data one clock after the read strobe.

A translation engine, which is outside this block, reports faults on an event port. The event carries a context number, a set of fault flags and the faulting I/O address. The bank latches the first fault address and accumulates flags until software clears the status word. Software clears it by writing zero to it, not by writing ones. A TLB invalidation request is raised by setting the flush bit in a control word. The bit stays visible as 1, and the matching `flush_req` line stays high, until the engine pulses the context's `flush_done` line. A single interrupt line is raised while any context with interrupts enabled holds a fault.

Top module: `iommu_ctx_regbank`

## Requirements
- R1: Context `n` occupies the 64-byte window at `BASE_ADDR + n*0x40`. The register offsets inside a window are: control 0x00, translation config 0x08, table base low 0x10, table base high 0x14, status 0x20, fault address low 0x30 and fault address high 0x34. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`.
- R2: Control bit 0 is translation enable and bit 2 is interrupt enable. Both read back as written, and bit 0 drives `ctx_en[n]`. Writing 0 to the control word clears both.
- R3: Writing 1 to control bit 1 starts a flush. The bit then reads 1 and `flush_req[n]` is high until a `flush_done[n]` pulse, after which both are 0. Writing 0 to bit 1 does not cancel a pending flush, and `flush_done` of another context has no effect on it.
- R4: An event whose flags include any of bits 4 (multiple hit), 2 (walk abort), 1 (page fault) or 0 (translation fault) records those flags in status bits 4, 2, 1 and 0, provided the context's status is zero. Flag bit 3 is dropped. The event also captures `evt_addr[31:0]` into the low fault address word and `evt_addr[39:32]`, zero-extended, into the high word.
- R5: An event on a context whose status is already non-zero ORs its flags into the status word and leaves both fault address words unchanged.
- R6: Writing 0 to the status word clears all its flags and makes both fault address words read 0. Writing any non-zero value leaves the status word and the fault address unchanged.
- R7: `irq` is high exactly when some context has interrupt enable set and a non-zero status word.
- R8: Translation config and both table base words are 32-bit read/write storage. Bit 31 of translation config (long-descriptor format) drives `ctx_long_desc[n]`.
- R9: Reads of unimplemented offsets, and reads of addresses outside the bank, return 0. Writes to them change no register.
- R10: After reset every register reads 0, and `irq`, `flush_req`, `ctx_en` and `ctx_long_desc` are all 0.
- R11: A status write of 0 in the same cycle as an event on the same context leaves the event's flags and address recorded, as a first fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| evt_valid | input | 1 | Fault event strobe from the translation engine |
| evt_ctx | input | CTX_IDX_W (3) | Context number of the event |
| evt_flags | input | 5 | Fault flags, same bit layout as the status word |
| evt_addr | input | ERR_ADDR_W (40) | Faulting I/O address |
| flush_done | input | NUM_CTX (8) | Per-context invalidation-complete pulse |
| flush_req | output | NUM_CTX (8) | Per-context pending-flush level |
| ctx_en | output | NUM_CTX (8) | Per-context translation enable |
| ctx_long_desc | output | NUM_CTX (8) | Per-context long-descriptor format select |
| irq | output | 1 | Combined fault interrupt |

## Verification
A table of writes and readbacks is spread over the first, middle and last contexts and over addresses below, inside and above the bank. It shows the address decode and the storage registers. It also shows that a write lands in one context only and that holes read zero. Fault sequences give a first fault, then a second fault with a dropped flag bit, then a write of ones and then a write of zero. These separate first-address capture from flag accumulation and zero-clear from write-one-clear. Flush runs pulse the wrong context's completion line and write 0 over a pending flush, so that a bit which clears early can be told apart from one that waits for the engine. A write of zero to the status word in the same cycle as a fault decides which of the two wins.

// File: rtl/iommu_rb_pkg.sv
package iommu_rb_pkg;
  localparam int CTX_STRIDE = 64;
  localparam int OFF_W      = 6;

  localparam logic [OFF_W-1:0] OFF_CTRL   = 6'h00;
  localparam logic [OFF_W-1:0] OFF_TTCFG  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_TBL_LO = 6'h10;
  localparam logic [OFF_W-1:0] OFF_TBL_HI = 6'h14;
  localparam logic [OFF_W-1:0] OFF_STATUS = 6'h20;
  localparam logic [OFF_W-1:0] OFF_ERR_LO = 6'h30;
  localparam logic [OFF_W-1:0] OFF_ERR_HI = 6'h34;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_FLUSH = 1;
  localparam int CTRL_IEN   = 2;

  localparam int          STAT_W    = 5;
  localparam logic [4:0]  STAT_MASK = 5'b10111;
  localparam int          LONG_DESC_BIT = 31;
endpackage

// File: rtl/iommu_rb_decode.sv
module iommu_rb_decode
  import iommu_rb_pkg::*;
#(
  parameter int          NUM_CTX   = 8,
  parameter int          ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h100
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CTX-1:0] ctx_sel,
  output logic [OFF_W-1:0]   off
);
  localparam int IDX_W = ADDR_W + 1 - OFF_W;
  localparam logic [ADDR_W:0] BASE_EXT = {1'b0, BASE_ADDR};
  localparam logic [ADDR_W:0] BANK_EXT = (ADDR_W+1)'(NUM_CTX * CTX_STRIDE);

  logic [ADDR_W:0] rel;
  logic            in_bank;
  logic [IDX_W-1:0] idx;

  assign rel     = {1'b0, addr} - BASE_EXT;
  assign in_bank = ({1'b0, addr} >= BASE_EXT) && (rel < BANK_EXT);
  assign idx     = rel[ADDR_W:OFF_W];
  assign off     = rel[OFF_W-1:0];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_sel
    assign ctx_sel[g] = in_bank && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/iommu_ctx_regs.sv
module iommu_ctx_regs
  import iommu_rb_pkg::*;
#(
  parameter int ERR_ADDR_W = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [OFF_W-1:0]      off,
  input  logic [31:0]           wdata,
  input  logic                  evt_hit,
  input  logic [STAT_W-1:0]     evt_flags,
  input  logic [ERR_ADDR_W-1:0] evt_addr,
  input  logic                  flush_done,
  output logic [31:0]           rdata,
  output logic                  en,
  output logic                  ien,
  output logic                  flush_pend,
  output logic                  long_desc,
  output logic                  fault_any
);
  localparam int HI_W = ERR_ADDR_W - 32;

  logic              en_q, ien_q, flush_q;
  logic              en_d, ien_d, flush_d;
  logic [31:0]       ttcfg_q, tbl_lo_q, tbl_hi_q;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [31:0]       err_lo_q, err_lo_d;
  logic [HI_W-1:0]   err_hi_q, err_hi_d;

  logic wr_ctrl, wr_ttcfg, wr_tlo, wr_thi, wr_stat, stat_clr, evt_take;
  logic [STAT_W-1:0] new_flags, stat_base;

  assign wr_ctrl  = wr_en && (off == OFF_CTRL);
  assign wr_ttcfg = wr_en && (off == OFF_TTCFG);
  assign wr_tlo   = wr_en && (off == OFF_TBL_LO);
  assign wr_thi   = wr_en && (off == OFF_TBL_HI);
  assign wr_stat  = wr_en && (off == OFF_STATUS);
  assign stat_clr = wr_stat && (wdata == 32'd0);
  assign new_flags = evt_flags & STAT_MASK;
  assign evt_take  = evt_hit && (new_flags != '0);

  always_comb begin
    en_d    = wr_ctrl ? wdata[CTRL_EN]  : en_q;
    ien_d   = wr_ctrl ? wdata[CTRL_IEN] : ien_q;
    flush_d = flush_q;
    if (flush_done) flush_d = 1'b0;
    if (wr_ctrl && wdata[CTRL_FLUSH]) flush_d = 1'b1;
  end

  always_comb begin
    stat_base = stat_clr ? '0 : stat_q;
    err_lo_d  = stat_clr ? '0 : err_lo_q;
    err_hi_d  = stat_clr ? '0 : err_hi_q;
    stat_d    = stat_base;
    if (evt_take) begin
      stat_d = stat_base | new_flags;
      if (stat_base == '0) begin
        err_lo_d = evt_addr[31:0];
        err_hi_d = evt_addr[ERR_ADDR_W-1:32];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ien_q    <= 1'b0;
      flush_q  <= 1'b0;
      stat_q   <= '0;
      err_lo_q <= '0;
      err_hi_q <= '0;
    end else begin
      en_q     <= en_d;
      ien_q    <= ien_d;
      flush_q  <= flush_d;
      stat_q   <= stat_d;
      err_lo_q <= err_lo_d;
      err_hi_q <= err_hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ttcfg_q  <= '0;
      tbl_lo_q <= '0;
      tbl_hi_q <= '0;
    end else begin
      if (wr_ttcfg) ttcfg_q  <= wdata;
      if (wr_tlo)   tbl_lo_q <= wdata;
      if (wr_thi)   tbl_hi_q <= wdata;
    end
  end

  always_comb begin
    case (off)
      OFF_CTRL:   rdata = {29'd0, ien_q, flush_q, en_q};
      OFF_TTCFG:  rdata = ttcfg_q;
      OFF_TBL_LO: rdata = tbl_lo_q;
      OFF_TBL_HI: rdata = tbl_hi_q;
      OFF_STATUS: rdata = 32'(stat_q);
      OFF_ERR_LO: rdata = err_lo_q;
      OFF_ERR_HI: rdata = 32'(err_hi_q);
      default:    rdata = 32'd0;
    endcase
  end

  assign en         = en_q;
  assign ien        = ien_q;
  assign flush_pend = flush_q;
  assign long_desc  = ttcfg_q[LONG_DESC_BIT];
  assign fault_any  = (stat_q != '0);

  // R3: a pending flush waits for the engine
  p_flush_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q && !flush_done |=> flush_q);
  // R3: completion clears the flush unless re-requested
  p_flush_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q && flush_done && !(wr_ctrl && wdata[CTRL_FLUSH]) |=> !flush_q);
  // R5: later faults keep the first address
  p_keep_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != '0) && evt_hit && !wr_stat |=> $stable(err_lo_q) && $stable(err_hi_q));
  // R6: non-zero write does not clear
  p_wr1_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && (wdata != 32'd0) && !evt_hit |=> $stable(stat_q));
  // R6: zero write clears flags and address
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr && !evt_hit |=> (stat_q == '0) && (err_lo_q == '0) && (err_hi_q == '0));
endmodule

// File: rtl/iommu_ctx_regbank.sv
module iommu_ctx_regbank
  import iommu_rb_pkg::*;
#(
  parameter int NUM_CTX    = 8,
  parameter int ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h100,
  parameter int ERR_ADDR_W = 40,
  localparam int CTX_IDX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic                  evt_valid,
  input  logic [CTX_IDX_W-1:0]  evt_ctx,
  input  logic [STAT_W-1:0]     evt_flags,
  input  logic [ERR_ADDR_W-1:0] evt_addr,
  input  logic [NUM_CTX-1:0]    flush_done,
  output logic [NUM_CTX-1:0]    flush_req,
  output logic [NUM_CTX-1:0]    ctx_en,
  output logic [NUM_CTX-1:0]    ctx_long_desc,
  output logic                  irq
);
  logic rst_meta, rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic [NUM_CTX-1:0] ctx_sel, evt_hit, ien, fault_any;
  logic [OFF_W-1:0]   off;
  logic [31:0]        ctx_rdata [NUM_CTX];
  logic [31:0]        rd_mux;

  iommu_rb_decode #(
    .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr(bus_addr), .ctx_sel(ctx_sel), .off(off)
  );

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    assign evt_hit[g] = evt_valid && (evt_ctx == CTX_IDX_W'(g));

    iommu_ctx_regs #(.ERR_ADDR_W(ERR_ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_sn),
      .wr_en      (bus_wr && ctx_sel[g]),
      .off        (off),
      .wdata      (bus_wdata),
      .evt_hit    (evt_hit[g]),
      .evt_flags  (evt_flags),
      .evt_addr   (evt_addr),
      .flush_done (flush_done[g]),
      .rdata      (ctx_rdata[g]),
      .en         (ctx_en[g]),
      .ien        (ien[g]),
      .flush_pend (flush_req[g]),
      .long_desc  (ctx_long_desc[g]),
      .fault_any  (fault_any[g])
    );
  end

  always_comb begin
    rd_mux = 32'd0;
    for (int i = 0; i < NUM_CTX; i++)
      if (ctx_sel[i]) rd_mux = rd_mux | ctx_rdata[i];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) bus_rdata <= 32'd0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq = |(ien & fault_any);

  // R1: at most one context decodes an address
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(ctx_sel));
  // R7: interrupt rises only after a fault event or a register write
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq) |-> $past(evt_valid || bus_wr));
  // R7: interrupt falls only after a register write
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(irq) |-> $past(bus_wr));
endmodule

// File: tb/iommu_ctx_regbank_tb.sv
module iommu_ctx_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        evt_valid;
  logic [2:0]  evt_ctx;
  logic [4:0]  evt_flags;
  logic [39:0] evt_addr;
  logic [7:0]  flush_done, flush_req, ctx_en, ctx_long_desc;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  iommu_ctx_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_valid(evt_valid), .evt_ctx(evt_ctx), .evt_flags(evt_flags),
    .evt_addr(evt_addr), .flush_done(flush_done), .flush_req(flush_req),
    .ctx_en(ctx_en), .ctx_long_desc(ctx_long_desc), .irq(irq)
  );

  function automatic logic [11:0] ra(input int ctx, input int off);
    return 12'(32'h100 + ctx * 64 + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic fault(input int ctx, input logic [4:0] f, input logic [39:0] a);
    @(negedge clk);
    evt_valid = 1'b1; evt_ctx = 3'(ctx); evt_flags = f; evt_addr = a;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  // {is_read, addr, data/expected}
  localparam int NV = 16;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 12'h108, 32'h8000_0005},  // R8 ctx0 config
    {1'b1, 12'h108, 32'h8000_0005},  // R8
    {1'b0, 12'h150, 32'h1234_5000},  // R1 ctx1 table low
    {1'b1, 12'h150, 32'h1234_5000},  // R1
    {1'b0, 12'h1D4, 32'h0000_00AB},  // R1 ctx3 table high
    {1'b1, 12'h1D4, 32'h0000_00AB},  // R1
    {1'b0, 12'h2C8, 32'h0000_0001},  // R1 ctx7 config
    {1'b1, 12'h2C8, 32'h0000_0001},  // R1
    {1'b0, 12'h104, 32'hFFFF_FFFF},  // R9 hole
    {1'b1, 12'h104, 32'h0000_0000},  // R9
    {1'b0, 12'h0F0, 32'hFFFF_FFFF},  // R9 below bank
    {1'b1, 12'h0F0, 32'h0000_0000},  // R9
    {1'b0, 12'h300, 32'hFFFF_FFFF},  // R9 above bank
    {1'b1, 12'h300, 32'h0000_0000},  // R9
    {1'b1, 12'h108, 32'h8000_0005},  // R9 untouched by hole write
    {1'b1, 12'h148, 32'h0000_0000}   // R1 ctx1 config isolated
  };

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    evt_valid = 0; evt_ctx = '0; evt_flags = '0; evt_addr = '0; flush_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check("R10 irq", 32'(irq), 0);
    check("R10 flush_req", 32'(flush_req), 0);
    check("R10 ctx_en", 32'(ctx_en), 0);
    check("R10 long_desc", 32'(ctx_long_desc), 0);
    rdchk("R10 ctrl", ra(0, 'h00), 0);
    rdchk("R10 status", ra(4, 'h20), 0);
    rdchk("R10 err_lo", ra(7, 'h30), 0);

    // R1 R8 R9 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) begin
        rd(VEC[i][43:32], d);
        check($sformatf("R1/R8/R9 vec%0d", i), d, VEC[i][31:0]);
      end else begin
        wr(VEC[i][43:32], VEC[i][31:0]);
      end
    end
    check("R8 long_desc", 32'(ctx_long_desc), 32'h01);

    // R2 control
    wr(ra(2, 'h00), 32'h5);
    rdchk("R2 ctrl rb", ra(2, 'h00), 32'h5);
    check("R2 ctx_en", 32'(ctx_en), 32'h04);
    wr(ra(2, 'h00), 32'h0);
    rdchk("R2 ctrl off", ra(2, 'h00), 32'h0);
    check("R2 ctx_en off", 32'(ctx_en), 0);

    // R3 flush handshake
    wr(ra(2, 'h00), 32'h2);
    check("R3 flush_req set", 32'(flush_req), 32'h04);
    rdchk("R3 ctrl pending", ra(2, 'h00), 32'h2);
    wr(ra(2, 'h00), 32'h0);
    rdchk("R3 no cancel", ra(2, 'h00), 32'h2);
    @(negedge clk); flush_done = 8'h20;
    @(negedge clk); flush_done = 8'h00;
    check("R3 other done ignored", 32'(flush_req), 32'h04);
    @(negedge clk); flush_done = 8'h04;
    @(negedge clk); flush_done = 8'h00;
    check("R3 flush cleared", 32'(flush_req), 0);
    rdchk("R3 ctrl cleared", ra(2, 'h00), 32'h0);

    // R4 first fault
    wr(ra(5, 'h00), 32'h4);
    fault(5, 5'b00010, 40'hAB_1234_5678);
    rdchk("R4 status", ra(5, 'h20), 32'h02);
    rdchk("R4 err_lo", ra(5, 'h30), 32'h1234_5678);
    rdchk("R4 err_hi", ra(5, 'h34), 32'h0000_00AB);
    check("R7 irq on", 32'(irq), 1);

    // R5 second fault, bit 3 dropped
    fault(5, 5'b11001, 40'h00_DEAD_0000);
    rdchk("R5 status or", ra(5, 'h20), 32'h13);
    rdchk("R5 err_lo kept", ra(5, 'h30), 32'h1234_5678);
    rdchk("R5 err_hi kept", ra(5, 'h34), 32'h0000_00AB);

    // R6 clear semantics
    wr(ra(5, 'h20), 32'h1F);
    rdchk("R6 ones no clear", ra(5, 'h20), 32'h13);
    check("R6 irq kept", 32'(irq), 1);
    wr(ra(5, 'h20), 32'h0);
    rdchk("R6 status zero", ra(5, 'h20), 0);
    rdchk("R6 err_lo zero", ra(5, 'h30), 0);
    rdchk("R6 err_hi zero", ra(5, 'h34), 0);
    check("R6 irq off", 32'(irq), 0);

    // R7 interrupt enable gating
    fault(6, 5'b00001, 40'h01_0000_0040);
    check("R7 masked", 32'(irq), 0);
    rdchk("R7 status held", ra(6, 'h20), 32'h01);
    wr(ra(6, 'h00), 32'h4);
    check("R7 unmasked", 32'(irq), 1);

    // R11 same-cycle clear and fault
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ra(6, 'h20); bus_wdata = 32'h0;
    evt_valid = 1'b1; evt_ctx = 3'd6; evt_flags = 5'b00100; evt_addr = 40'h77_0000_1111;
    @(negedge clk);
    bus_wr = 1'b0; evt_valid = 1'b0;
    rdchk("R11 status", ra(6, 'h20), 32'h04);
    rdchk("R11 err_lo", ra(6, 'h30), 32'h0000_1111);
    rdchk("R11 err_hi", ra(6, 'h34), 32'h0000_0077);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule